// File: doc/BRIEF.md
# Indexed Clock and Configuration Register Bank

This block is a bank of 128 byte-wide registers that software reaches through two ports: an index port and a data port. A write to the index port selects a location. Later accesses to the data port read or write that location. The low locations hold time and alarm fields and four control/status registers, named A through D. The remaining locations are general storage. The block does not count time or match alarms. It stores whatever software writes, except into the two status registers, which cannot be written.

Reads of the data port can change state. A read of register A returns its value and then flips its update-in-progress bit, so polling software sees that bit alternate. A read of register C returns its value, clears the register and drops the interrupt line. A periodic tick input raises the interrupt when the periodic-enable bit in register B is set. The interrupt stays high until software reads register C.

Read data comes from combinational logic and is valid during the strobe cycle. All state changes take effect at the clock edge that ends the strobe cycle.

Top module: `rtc_regbank`

## Requirements
- R1: A write to the index port (busAddr=0) stores only bits 6:0 of the data byte as the selected index. Bit 7 is discarded.
- R2: A read of the index port (busAddr=0) returns 0xFF.
- R3: A write to the data port (busAddr=1) stores the byte at the selected index. This applies to every index except 0x0C and 0x0D, including time/alarm fields 0x00–0x09, register A (0x0A), register B (0x0B) and storage 0x0E–0x7F. A later data-port read at that index returns the stored byte.
- R4: Data-port writes to register C (0x0C) and register D (0x0D) leave the stored value unchanged.
- R5: A data-port read of register A (0x0A) returns its current value. At the end of that cycle, bit 7 of register A is inverted, so back-to-back reads alternate bit 7.
- R6: When tick is high at a clock edge and bit 6 of register B (0x0B) is set, irqOut is high after that edge.
- R7: Once high, irqOut stays high, whatever further ticks arrive, until a data-port read of register C. That read returns the current value of C, and after its clock edge C holds 0x00 and irqOut is low.
- R8: A tick while bit 6 of register B is clear leaves irqOut low.
- R9: After reset, every location holds 0x00, the selected index is 0 and irqOut is low.
- R10: If a read of register C and an enabled tick share a clock edge, the tick wins and irqOut stays high. C is still cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Single-cycle access strobe |
| busWe | input | 1 | 1 = write, 0 = read, qualified by busSel |
| busAddr | input | 1 | 0 = index port, 1 = data port |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the strobe cycle |
| tick | input | 1 | Periodic interrupt tick |
| irqOut | output | 1 | Interrupt request, high until register C is read |

## Verification
A wrong latched index shows up at the very next data-port read, which returns the byte of the wrong location. A write protection that fails on C or D shows up one read later as a non-zero value. A missed toggle of register A appears on the second of two consecutive reads. A wrong interrupt flop is visible on irqOut one edge after the tick or the register C read. Because of this, the bench checks bit 7 of A on every read and samples irqOut after every tick, in both the enabled and disabled cases and in the case where a tick and a register C read coincide.

// File: rtl/rtc_regbank_pkg.sv
package rtc_regbank_pkg;
  localparam int REG_A_IDX = 10;
  localparam int REG_B_IDX = 11;
  localparam int REG_C_IDX = 12;
  localparam int REG_D_IDX = 13;
  localparam int UIP_BIT   = 7;
  localparam int PIE_BIT   = 6;

  typedef struct packed {
    logic idxWr;
    logic memWr;
    logic toggleA;
    logic clearC;
  } bankStrobes_t;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_regbank_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWe,
  input  logic             busAddr,
  input  logic             tick,
  input  logic [IDX_W-1:0] curIdx,
  input  logic             periodicEn,
  output bankStrobes_t     strobes,
  output logic             irqOut
);
  logic wrAcc, rdData, idxIsC, idxIsD;
  logic irqQ;

  assign wrAcc  = busSel && busWe;
  assign rdData = busSel && !busWe && busAddr;
  assign idxIsC = (curIdx == IDX_W'(REG_C_IDX));
  assign idxIsD = (curIdx == IDX_W'(REG_D_IDX));

  always_comb begin
    strobes.idxWr   = wrAcc && !busAddr;
    strobes.memWr   = wrAcc && busAddr && !idxIsC && !idxIsD;
    strobes.toggleA = rdData && (curIdx == IDX_W'(REG_A_IDX));
    strobes.clearC  = rdData && idxIsC;
  end

  // Tick has priority over the clear so no event is lost.
  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else if (tick && periodicEn) irqQ <= 1'b1;
    else if (strobes.clearC) irqQ <= 1'b0;
  end

  assign irqOut = irqQ;

  assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tick && periodicEn) |=> irqOut);

  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !(busSel && !busWe && busAddr && idxIsC)) |=> irqOut);

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!irqOut && !(tick && periodicEn)) |=> !irqOut);
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_regbank_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobes_t      strobes,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [IDX_W-1:0]  curIdx,
  output logic              periodicEn
);
  localparam int NUM_REGS = 1 << IDX_W;

  logic [DATA_W-1:0] bank [NUM_REGS];
  logic [IDX_W-1:0]  idxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
    end else begin
      if (strobes.idxWr) idxQ <= busWdata[IDX_W-1:0];
      if (strobes.memWr) bank[idxQ] <= busWdata;
      if (strobes.toggleA) bank[REG_A_IDX][UIP_BIT] <= ~bank[REG_A_IDX][UIP_BIT];
      if (strobes.clearC) bank[REG_C_IDX] <= '0;
    end
  end

  assign curIdx     = idxQ;
  assign periodicEn = bank[REG_B_IDX][PIE_BIT];
  assign busRdata   = busAddr ? bank[idxQ] : '1;

  assert_idx_low_bits_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.idxWr |=> (curIdx == $past(busWdata[IDX_W-1:0])));

  assert_protect_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.memWr |-> (idxQ != IDX_W'(REG_C_IDX) && idxQ != IDX_W'(REG_D_IDX)));

  assert_uip_flip_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.toggleA |=> (bank[REG_A_IDX][UIP_BIT] != $past(bank[REG_A_IDX][UIP_BIT])));

  assert_c_cleared_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearC |=> (bank[REG_C_IDX] == '0));
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_regbank_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tick,
  output logic              irqOut
);
  bankStrobes_t     strobes;
  logic [IDX_W-1:0] curIdx;
  logic             periodicEn;

  rtc_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .tick(tick), .curIdx(curIdx),
    .periodicEn(periodicEn), .strobes(strobes), .irqOut(irqOut)
  );

  rtc_datapath #(.IDX_W(IDX_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .curIdx(curIdx),
    .periodicEn(periodicEn)
  );

  assert_index_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWe && !busAddr) |-> (busRdata == '1));
endmodule

// File: tb/tb_rtc_regbank.sv
module tb_rtc_regbank;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWe = 1'b0, busAddr = 1'b0, tick = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic irqOut;

  int total = 0;
  int bad = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  rtc_regbank dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .tick(tick), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  // Monitor: compares read data with queued expectations mid-cycle.
  initial forever begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (busSel && !busWe) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard actual=0x%02h expected=none", busRdata);
      end else begin
        check(busRdata, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  task automatic busWrite(input logic addr, input logic [7:0] data);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = addr; busWdata = data;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic addr, input logic [7:0] exp, input string tag,
                         input logic withTick);
    @(negedge clk);
    expQ.push_back(exp); tagQ.push_back(tag);
    busSel = 1'b1; busWe = 1'b0; busAddr = addr; tick = withTick;
    @(negedge clk);
    busSel = 1'b0; tick = 1'b0;
  endtask

  task automatic pulseTick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic checkIrq(input logic exp, input string tag);
    #1 check({7'd0, irqOut}, {7'd0, exp}, tag);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9: reset state
    checkIrq(1'b0, "R9 irq after reset");
    busRead(1'b1, 8'h00, "R9 index 0 content", 1'b0);
    busWrite(1'b0, 8'h7F);
    busRead(1'b1, 8'h00, "R9 storage 0x7F cleared", 1'b0);
    // R2
    busRead(1'b0, 8'hFF, "R2 index port read", 1'b0);
    // R1 and R3
    busWrite(1'b0, 8'h85);
    busWrite(1'b1, 8'h3C);
    busWrite(1'b0, 8'h05);
    busRead(1'b1, 8'h3C, "R1 bit7 dropped from index", 1'b0);
    busWrite(1'b0, 8'h7F);
    busWrite(1'b1, 8'hA5);
    busRead(1'b1, 8'hA5, "R3 storage 0x7F", 1'b0);
    busWrite(1'b0, 8'h02);
    busWrite(1'b1, 8'h59);
    busRead(1'b1, 8'h59, "R3 time field 0x02", 1'b0);
    busWrite(1'b0, 8'h05);
    busRead(1'b1, 8'h3C, "R3 location 0x05 kept", 1'b0);
    // R4
    busWrite(1'b0, 8'h0C);
    busWrite(1'b1, 8'h55);
    busRead(1'b1, 8'h00, "R4 register C write ignored", 1'b0);
    busWrite(1'b0, 8'h0D);
    busWrite(1'b1, 8'hAA);
    busRead(1'b1, 8'h00, "R4 register D write ignored", 1'b0);
    // R5
    busWrite(1'b0, 8'h0A);
    busWrite(1'b1, 8'h26);
    busRead(1'b1, 8'h26, "R5 first A read", 1'b0);
    busRead(1'b1, 8'hA6, "R5 second A read", 1'b0);
    busRead(1'b1, 8'h26, "R5 third A read", 1'b0);
    // R8
    busWrite(1'b0, 8'h0B);
    busWrite(1'b1, 8'h00);
    pulseTick();
    checkIrq(1'b0, "R8 tick while disabled");
    // R6
    busWrite(1'b1, 8'h40);
    busRead(1'b1, 8'h40, "R3 register B stored", 1'b0);
    checkIrq(1'b0, "R6 no irq before tick");
    pulseTick();
    checkIrq(1'b1, "R6 irq after enabled tick");
    // R7
    pulseTick();
    checkIrq(1'b1, "R7 irq held across tick");
    busRead(1'b1, 8'h40, "R7 unrelated read", 1'b0);
    checkIrq(1'b1, "R7 irq held across other read");
    busWrite(1'b0, 8'h0C);
    busRead(1'b1, 8'h00, "R7 C read value", 1'b0);
    checkIrq(1'b0, "R7 irq cleared by C read");
    // R10
    pulseTick();
    checkIrq(1'b1, "R10 irq set again");
    busRead(1'b1, 8'h00, "R10 C read with tick", 1'b1);
    checkIrq(1'b1, "R10 tick wins over clear");
    busRead(1'b1, 8'h00, "R10 C read alone", 1'b0);
    checkIrq(1'b0, "R10 irq cleared later");
    repeat (2) @(negedge clk);
    if (expQ.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", expQ.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule